// File: doc/BRIEF.md
# Strobed Serial Command Interface

This block terminates a three-wire host port made of a strobe, a shift clock and one open-drain data line. It turns the host's byte stream into control state and memory write strobes for a display panel controller. While the strobe is high, bytes arrive most significant bit first. The first complete byte of each strobe window is a command, and every later byte in that window is data. Commands choose the panel configuration, the target and addressing mode for data bytes, the current address, and a status word.

Data bytes go out as single-cycle write strobes with a target, address, row and data. They can target the display data RAM, the character RAM or the user-font RAM. A data byte can instead set the LED latch, which the block holds itself. When the data mode is key read, the block ignores incoming data bytes. It then shifts the key matrix bytes out on the data line, changing each bit on a falling shift-clock edge.

All three serial inputs are sampled in the block's own clock domain through a synchronizer. The host's shift-clock half period must therefore be at least four block clock periods.

Top module: `scmd_if`

## Requirements
- R1: Synchronous active-low reset clears every mode, address, status and configuration register and the LED latch to zero, raises no write strobe and releases the data line.
- R2: Bits are shifted in on rising shift-clock edges while the strobe is high, MSB first. The first complete byte after the strobe rises is decoded as a command, and every later byte in that window is treated as data, whatever its value.
- R3: If the strobe falls before a byte's eighth rising edge, that partial byte has no effect, while bytes completed earlier in the window keep their effect.
- R4: The command class is taken from bits 7:6: 00 panel setup, 01 data setup, 10 address, 11 status. A status command loads bits 1:0 into the LCD mode, bit 2 into LED enable, bit 3 into key-scan enable, bit 4 into standby and bit 5 into test mode.
- R5: A panel setup command takes duty from bit 0, slave select from bit 1 and internal supply from bit 2. When this 3-bit value differs from the one held, it is stored and the LCD mode and key-scan enable are cleared. When it is equal, nothing changes.
- R6: A data setup command takes its mode from bits 2:0 and fixed addressing from bit 3. The mode codes are 000 display RAM, 001 character RAM, 010 user-font RAM, 011 LED latch and 100 key read. Codes 101 to 111 make data bytes do nothing. The target code of each write strobe equals the mode code.
- R7: In display and character modes each accepted data byte gives one write strobe carrying the current address and the byte unchanged. The address then advances by one unless fixed addressing is selected.
- R8: A write happens only while the address is in range for the current mode: 0 to 24 for display, 0 to 7 for character, 0 to 15 for user font. Out of range, data bytes are dropped and the address does not move until an address command sets a valid one.
- R9: In user-font mode the address is the character code and does not advance. Each data byte gives the row from bits 7:5 and the dots from bits 4:0, which appear on the data output with the top three bits zero. A byte whose row field is 7 is dropped.
- R10: In LED mode each data byte loads its low four bits into the LED latch output, and the upper bits are ignored.
- R11: After a key-read data setup command, the data bytes of that window return key_data_i[31:24], [23:16], [15:8] and [7:0] in that order, MSB first. Each bit is presented on a falling shift-clock edge, with the first bit on the first falling edge after the command. A 0 pulls the line low and a 1 releases it. Later bytes read all ones, and no write strobe is raised.
- R12: While the strobe is low the data line is released, and a strobe fall ends any key read in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_stb_i | input | 1 | Host strobe, transfer window while high |
| ser_sck_i | input | 1 | Host shift clock, idles high |
| ser_dat_i | input | 1 | Serial data line as seen at the pin |
| ser_dat_pull_o | output | 1 | 1 pulls the open-drain data line low |
| key_data_i | input | 32 | Key matrix bytes, bits 31:24 sent first |
| wr_en_o | output | 1 | Single-cycle write strobe |
| wr_tgt_o | output | 3 | Write target: 0 display, 1 character, 2 user font |
| wr_addr_o | output | 5 | Write address or character code |
| wr_row_o | output | 3 | Font row for user-font writes, else 0 |
| wr_data_o | output | 8 | Write data |
| led_o | output | 4 | LED latch |
| duty_o | output | 1 | Panel duty select |
| slave_o | output | 1 | Slave select |
| int_supply_o | output | 1 | Internal drive supply select |
| lcd_mode_o | output | 2 | LCD mode field of the status word |
| led_en_o | output | 1 | LED enable |
| scan_en_o | output | 1 | Key-scan enable |
| standby_o | output | 1 | Standby request |
| test_mode_o | output | 1 | Test mode |

## Verification
The hardest case to reach is a window cut short. The strobe falls after some complete bytes and partway through the next one, and the completed bytes must still take effect while the partial one leaves no trace. The bench stops shifting after a chosen number of bits inside a window, both in the command byte and in a data byte, and then opens a fresh window to show that framing restarts with a command. Key reads are equally delicate, because the first output bit must appear on the very first falling edge after the command. The bench samples the pull output just before each rising edge across more bytes than the key word holds, and drops the strobe in the middle of a read.

// File: rtl/scmd_pkg.sv
// Shared types for the strobed serial command interface.
// Assumes: command class in the top two bits of a command byte.
package scmd_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        CLS_SETUP  = 2'b00,
        CLS_DATA   = 2'b01,
        CLS_ADDR   = 2'b10,
        CLS_STATUS = 2'b11
    } cmd_cls_e;

    localparam logic [2:0] MODE_DISP = 3'd0;
    localparam logic [2:0] MODE_CHAR = 3'd1;
    localparam logic [2:0] MODE_FONT = 3'd2;
    localparam logic [2:0] MODE_LED  = 3'd3;
    localparam logic [2:0] MODE_KEY  = 3'd4;

    // Status word, packed so that bit 5 is test and bits 1:0 the LCD mode.
    typedef struct packed {
        logic       test;
        logic       standby;
        logic       scan;
        logic       led;
        logic [1:0] lcd;
    } status_t;

    // Panel setup word: bit 2 supply, bit 1 slave, bit 0 duty.
    typedef struct packed {
        logic int_sup;
        logic slave;
        logic duty;
    } setup_t;

endpackage

// File: rtl/scmd_sync_edge.sv
// Synchronizes strobe, shift clock and data into the block clock and
// derives strobe-rise and shift-clock edges.
// Assumes: all three inputs are asynchronous; the host holds each
// shift-clock level for more than STAGES+1 block clocks.
module scmd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic sck_i,
    input  logic dat_i,
    output logic stb_o,
    output logic stb_rise_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic dat_o
);
    localparam logic [2:0] IDLE = 3'b011; // {stb, sck, dat}

    logic [STAGES-1:0][2:0] pipe_q;
    logic [1:0]             prev_q;   // {stb, sck} one clock later

    // Synchronizer chain for {strobe, clock, data}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= IDLE;
        end else begin
            pipe_q[0] <= {stb_i, sck_i, dat_i};
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE[2:1];
        else        prev_q <= pipe_q[STAGES-1][2:1];
    end

    assign stb_o      = pipe_q[STAGES-1][2];
    assign dat_o      = pipe_q[STAGES-1][0];
    assign stb_rise_o = pipe_q[STAGES-1][2] & ~prev_q[1];
    assign sck_rise_o = pipe_q[STAGES-1][1] & ~prev_q[0];
    assign sck_fall_o = ~pipe_q[STAGES-1][1] & prev_q[0];

endmodule

// File: rtl/scmd_shifter.sv
// Byte framing and bit serialization. Assembles MSB-first bytes on
// shift-clock rises, tags the first byte of a strobe window as a
// command, and drives the open-drain pull on shift-clock falls.
// Assumes: synchronized inputs from scmd_sync_edge.
module scmd_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       stb_rise_i,
    input  logic       sck_rise_i,
    input  logic       sck_fall_i,
    input  logic       din_i,
    input  logic       tx_en_i,
    input  logic [7:0] tx_byte_i,
    output logic       byte_vld_o,
    output logic       byte_cmd_o,
    output logic [7:0] byte_o,
    output logic       pull_low_o
);
    logic [2:0] bit_cnt_q;
    logic [6:0] sr_q;
    logic       first_q;

    // Receive framing, byte hand-off and transmit bit drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            sr_q       <= '0;
            first_q    <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_cmd_o <= 1'b0;
            byte_o     <= '0;
            pull_low_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (!stb_i) begin
                bit_cnt_q  <= '0;
                pull_low_o <= 1'b0;
            end else begin
                if (stb_rise_i) begin
                    bit_cnt_q <= '0;
                    first_q   <= 1'b1;
                end else if (sck_rise_i) begin
                    sr_q      <= {sr_q[5:0], din_i};
                    bit_cnt_q <= bit_cnt_q + 3'd1;
                    if (bit_cnt_q == 3'd7) begin
                        byte_vld_o <= 1'b1;
                        byte_o     <= {sr_q, din_i};
                        byte_cmd_o <= first_q;
                        first_q    <= 1'b0;
                    end
                end
                if (sck_fall_i)
                    pull_low_o <= tx_en_i & ~tx_byte_i[~bit_cnt_q];
            end
        end
    end

    AST_LINE_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> !pull_low_o); // R12

    AST_BYTE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> ($past(sck_rise_i) && $past(stb_i))); // R2

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o); // R2

endmodule

// File: rtl/scmd_decode.sv
// Command decoder and data router. Holds the mode, address, status,
// panel setup and LED latch, issues write strobes with range checks,
// and selects the key byte to transmit during a key read.
// Assumes: byte_vld_i pulses are separated by many clocks.
module scmd_decode
    import scmd_pkg::*;
#(
    parameter int DISP_LAST = 24,
    parameter int CHAR_LAST = 7,
    parameter int FONT_LAST = 15,
    parameter int FONT_ROWS = 7,
    parameter int KEY_BYTES = 4,
    parameter int LED_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb_i,
    input  logic                  byte_vld_i,
    input  logic                  byte_cmd_i,
    input  logic [7:0]            byte_i,
    input  logic [KEY_BYTES*8-1:0] key_data_i,
    output logic                  wr_en_o,
    output logic [2:0]            wr_tgt_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [2:0]            wr_row_o,
    output logic [7:0]            wr_data_o,
    output logic [LED_W-1:0]      led_o,
    output setup_t                setup_o,
    output status_t               status_o,
    output logic                  tx_en_o,
    output logic [7:0]            tx_byte_o
);
    localparam int IDX_W = $clog2(KEY_BYTES + 1);
    localparam int SEL_W = $clog2(KEY_BYTES);
    localparam logic [ADDR_W-1:0] DISP_LAST_A = ADDR_W'(DISP_LAST);
    localparam logic [ADDR_W-1:0] CHAR_LAST_A = ADDR_W'(CHAR_LAST);
    localparam logic [ADDR_W-1:0] FONT_LAST_A = ADDR_W'(FONT_LAST);
    localparam logic [2:0]        ROWS_V      = 3'(FONT_ROWS);
    localparam logic [IDX_W-1:0]  KEY_BYTES_V = IDX_W'(KEY_BYTES);

    logic [2:0]        mode_q;
    logic              fixed_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic              addr_ok;
    logic [7:0]        key_bytes [KEY_BYTES];
    cmd_cls_e          cls;

    // Split the key word into bytes, most significant byte first.
    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
        assign key_bytes[g] = key_data_i[KEY_BYTES*8-1-8*g -: 8];
    end

    // Address range check for the current data mode.
    always_comb begin
        case (mode_q)
            MODE_DISP: addr_ok = (addr_q <= DISP_LAST_A);
            MODE_CHAR: addr_ok = (addr_q <= CHAR_LAST_A);
            MODE_FONT: addr_ok = (addr_q <= FONT_LAST_A);
            default:   addr_ok = 1'b0;
        endcase
    end

    assign cls       = cmd_cls_e'(byte_i[7:6]);
    assign tx_en_o   = rd_q && (rd_idx_q < KEY_BYTES_V);
    assign tx_byte_o = tx_en_o ? key_bytes[rd_idx_q[SEL_W-1:0]] : 8'hFF;

    // Command decode, data routing and key-read progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            fixed_q   <= 1'b0;
            addr_q    <= '0;
            rd_q      <= 1'b0;
            rd_idx_q  <= '0;
            wr_en_o   <= 1'b0;
            wr_tgt_o  <= '0;
            wr_addr_o <= '0;
            wr_row_o  <= '0;
            wr_data_o <= '0;
            led_o     <= '0;
            setup_o   <= '0;
            status_o  <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (!stb_i) begin
                rd_q     <= 1'b0;
                rd_idx_q <= '0;
            end
            if (byte_vld_i) begin
                if (byte_cmd_i) begin
                    case (cls)
                        CLS_SETUP: begin
                            if (byte_i[2:0] != setup_o) begin
                                setup_o      <= setup_t'(byte_i[2:0]);
                                status_o.lcd  <= 2'b00;
                                status_o.scan <= 1'b0;
                            end
                        end
                        CLS_DATA: begin
                            mode_q   <= byte_i[2:0];
                            fixed_q  <= byte_i[3];
                            rd_q     <= (byte_i[2:0] == MODE_KEY);
                            rd_idx_q <= '0;
                        end
                        CLS_ADDR:   addr_q   <= byte_i[ADDR_W-1:0];
                        default:    status_o <= status_t'(byte_i[5:0]);
                    endcase
                end else if (rd_q) begin
                    if (rd_idx_q < KEY_BYTES_V) rd_idx_q <= rd_idx_q + IDX_W'(1);
                end else begin
                    case (mode_q)
                        MODE_DISP, MODE_CHAR: begin
                            if (addr_ok) begin
                                wr_en_o   <= 1'b1;
                                wr_tgt_o  <= mode_q;
                                wr_addr_o <= addr_q;
                                wr_row_o  <= 3'd0;
                                wr_data_o <= byte_i;
                                if (!fixed_q) addr_q <= addr_q + ADDR_W'(1);
                            end
                        end
                        MODE_FONT: begin
                            if (addr_ok && (byte_i[7:5] < ROWS_V)) begin
                                wr_en_o   <= 1'b1;
                                wr_tgt_o  <= mode_q;
                                wr_addr_o <= addr_q;
                                wr_row_o  <= byte_i[7:5];
                                wr_data_o <= {3'b000, byte_i[4:0]};
                            end
                        end
                        MODE_LED: led_o <= byte_i[LED_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_DISP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_tgt_o == MODE_DISP) |-> (wr_addr_o <= DISP_LAST_A)); // R8

    AST_CHAR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_tgt_o == MODE_CHAR) |-> (wr_addr_o <= CHAR_LAST_A)); // R8

    AST_FONT_ROW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_tgt_o == MODE_FONT) |-> (wr_row_o < ROWS_V && wr_data_o[7:5] == 3'b000)); // R9

    AST_SETUP_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_o != $past(setup_o)) |-> (status_o.lcd == 2'b00 && !status_o.scan)); // R5

    AST_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> !wr_en_o); // R11

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o); // R7

endmodule

// File: rtl/scmd_if.sv
// Top of the strobed serial command interface: synchronizer, byte
// shifter and command decoder. Assumes the host's shift-clock half
// period spans at least SYNC_STAGES+2 block clocks.
module scmd_if
    import scmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DISP_LAST   = 24,
    parameter int CHAR_LAST   = 7,
    parameter int FONT_LAST   = 15,
    parameter int FONT_ROWS   = 7,
    parameter int KEY_BYTES   = 4,
    parameter int LED_W       = 4,
    localparam int KEY_W      = KEY_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_stb_i,
    input  logic              ser_sck_i,
    input  logic              ser_dat_i,
    output logic              ser_dat_pull_o,
    input  logic [KEY_W-1:0]  key_data_i,
    output logic              wr_en_o,
    output logic [2:0]        wr_tgt_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [2:0]        wr_row_o,
    output logic [7:0]        wr_data_o,
    output logic [LED_W-1:0]  led_o,
    output logic              duty_o,
    output logic              slave_o,
    output logic              int_supply_o,
    output logic [1:0]        lcd_mode_o,
    output logic              led_en_o,
    output logic              scan_en_o,
    output logic              standby_o,
    output logic              test_mode_o
);
    logic       stb, stb_rise, sck_rise, sck_fall, din;
    logic       byte_vld, byte_cmd, tx_en;
    logic [7:0] byte_val, tx_byte;
    setup_t     setup;
    status_t    status;

    scmd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (ser_stb_i),
        .sck_i      (ser_sck_i),
        .dat_i      (ser_dat_i),
        .stb_o      (stb),
        .stb_rise_o (stb_rise),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .dat_o      (din)
    );

    scmd_shifter i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .stb_rise_i (stb_rise),
        .sck_rise_i (sck_rise),
        .sck_fall_i (sck_fall),
        .din_i      (din),
        .tx_en_i    (tx_en),
        .tx_byte_i  (tx_byte),
        .byte_vld_o (byte_vld),
        .byte_cmd_o (byte_cmd),
        .byte_o     (byte_val),
        .pull_low_o (ser_dat_pull_o)
    );

    scmd_decode #(
        .DISP_LAST (DISP_LAST),
        .CHAR_LAST (CHAR_LAST),
        .FONT_LAST (FONT_LAST),
        .FONT_ROWS (FONT_ROWS),
        .KEY_BYTES (KEY_BYTES),
        .LED_W     (LED_W)
    ) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .byte_vld_i (byte_vld),
        .byte_cmd_i (byte_cmd),
        .byte_i     (byte_val),
        .key_data_i (key_data_i),
        .wr_en_o    (wr_en_o),
        .wr_tgt_o   (wr_tgt_o),
        .wr_addr_o  (wr_addr_o),
        .wr_row_o   (wr_row_o),
        .wr_data_o  (wr_data_o),
        .led_o      (led_o),
        .setup_o    (setup),
        .status_o   (status),
        .tx_en_o    (tx_en),
        .tx_byte_o  (tx_byte)
    );

    assign duty_o       = setup.duty;
    assign slave_o      = setup.slave;
    assign int_supply_o = setup.int_sup;
    assign lcd_mode_o   = status.lcd;
    assign led_en_o     = status.led;
    assign scan_en_o    = status.scan;
    assign standby_o    = status.standby;
    assign test_mode_o  = status.test;

endmodule

// File: tb/test_scmd_if.sv
// Self-checking bench: directed corner cases plus seeded random sessions,
// compared against a behavioural model written from the requirements.
module test_scmd_if;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // block clocks per shift-clock half

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stb, sck, dat;
    logic        pull;
    logic [31:0] key;
    logic        wr_en;
    logic [2:0]  wr_tgt, wr_row;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [3:0]  led;
    logic        duty, slave, isup, led_en, scan_en, stby, test;
    logic [1:0]  lcd;

    always #(CLK_PERIOD/2) clk = ~clk;

    scmd_if i_scmd_if (
        .clk(clk), .rst_n(rst_n), .ser_stb_i(stb), .ser_sck_i(sck), .ser_dat_i(dat),
        .ser_dat_pull_o(pull), .key_data_i(key), .wr_en_o(wr_en), .wr_tgt_o(wr_tgt),
        .wr_addr_o(wr_addr), .wr_row_o(wr_row), .wr_data_o(wr_data), .led_o(led),
        .duty_o(duty), .slave_o(slave), .int_supply_o(isup), .lcd_mode_o(lcd),
        .led_en_o(led_en), .scan_en_o(scan_en), .standby_o(stby), .test_mode_o(test)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Observed write log.
    logic [18:0] a_log [512];
    int          a_total = 0;
    always @(negedge clk) begin
        if (rst_n && wr_en && a_total < 512) begin
            a_log[a_total] = {wr_tgt, wr_addr, wr_row, wr_data};
            a_total++;
        end
    end

    // Expected log and model state.
    logic [18:0] e_log [64];
    int          e_n, base;
    logic [2:0]  m_mode, m_disp;
    logic        m_fixed, m_rd;
    logic [4:0]  m_addr;
    logic [3:0]  m_led;
    logic [5:0]  m_stat;
    bit          s_first;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic bit in_range(input logic [2:0] mode, input logic [4:0] a);
        case (mode)
            3'd0:    return a <= 5'd24;
            3'd1:    return a <= 5'd7;
            3'd2:    return a <= 5'd15;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input logic [2:0] t, input logic [4:0] a,
                        input logic [2:0] r, input logic [7:0] d);
        if (e_n < 64) e_log[e_n] = {t, a, r, d};
        e_n++;
    endtask

    // Model of one received byte (R4..R10).
    task automatic model_byte(input logic [7:0] b, input bit is_cmd);
        if (is_cmd) begin
            case (b[7:6])
                2'b00: if (b[2:0] != m_disp) begin
                    m_disp = b[2:0]; m_stat[1:0] = 2'b00; m_stat[3] = 1'b0;
                end
                2'b01: begin m_mode = b[2:0]; m_fixed = b[3]; m_rd = (b[2:0] == 3'd4); end
                2'b10: m_addr = b[4:0];
                default: m_stat = b[5:0];
            endcase
        end else if (!m_rd) begin
            case (m_mode)
                3'd0, 3'd1: if (in_range(m_mode, m_addr)) begin
                    push(m_mode, m_addr, 3'd0, b);
                    if (!m_fixed) m_addr = m_addr + 5'd1;
                end
                3'd2: if (in_range(m_mode, m_addr) && b[7:5] != 3'd7)
                    push(m_mode, m_addr, b[7:5], {3'b000, b[4:0]});
                3'd3: m_led = b[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int k);
        for (int i = 7; i > 7 - k; i--) begin
            sck = 1'b0; dat = b[i];
            wait_clks(HALF);
            sck = 1'b1;
            wait_clks(HALF);
        end
    endtask

    task automatic sess_open();
        base = a_total; e_n = 0; s_first = 1;
        stb = 1'b1;
        wait_clks(HALF);
    endtask

    task automatic sess_byte(input logic [7:0] b);
        model_byte(b, s_first);
        s_first = 0;
        send_bits(b, 8);
    endtask

    task automatic sess_close();
        dat = 1'b1; stb = 1'b0; m_rd = 1'b0;
        wait_clks(2 * HALF);
    endtask

    task automatic recv_bits(output logic [7:0] v, input int k);
        v = 8'h00;
        for (int i = 7; i > 7 - k; i--) begin
            sck = 1'b0; dat = 1'b1;
            wait_clks(HALF);
            v[i] = ~pull;
            sck = 1'b1;
            wait_clks(HALF);
        end
    endtask

    task automatic one_cmd(input logic [7:0] c);
        sess_open(); sess_byte(c); sess_close();
    endtask

    task automatic compare_log(input string req);
        check({req, " write count"}, a_total - base, e_n);
        for (int i = 0; i < e_n && i < 64; i++)
            if (base + i < a_total) check({req, " write entry"}, a_log[base + i], e_log[i]);
    endtask

    task automatic check_ctrl(input string req);
        check({req, " status"}, {test, stby, scan_en, led_en, lcd}, m_stat);
        check({req, " setup"}, {isup, slave, duty}, m_disp);
        check({req, " led"}, led, m_led);
    endtask

    task automatic key_read(input string req, input int nbytes);
        logic [7:0] v;
        sess_open(); sess_byte(8'h44);
        for (int i = 0; i < nbytes; i++) begin
            recv_bits(v, 8);
            check(req, v, (i < 4) ? key[31 - 8*i -: 8] : 8'hFF);
        end
        sess_close();
        compare_log({req, " no writes"});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; stb = 1'b0; sck = 1'b1; dat = 1'b1; key = 32'h0;
        m_mode = 0; m_disp = 0; m_fixed = 0; m_rd = 0; m_addr = 0; m_led = 0; m_stat = 0;
        e_n = 0; base = 0;
        wait_clks(6);
        rst_n = 1'b1;
        wait_clks(4);

        // R1: reset state
        check_ctrl("R1");
        check("R1 pull", pull, 1'b0);
        check("R1 no writes", a_total, 0);

        // R2: second byte is data even when it looks like a status command
        one_cmd(8'h40);
        sess_open(); sess_byte(8'h82); sess_byte(8'hC7); sess_close();
        compare_log("R2"); check_ctrl("R2");

        // R7 R8: increment runs off the end of display RAM
        sess_open(); sess_byte(8'h97); sess_byte(8'hA1); sess_byte(8'hA2); sess_byte(8'hA3); sess_close();
        compare_log("R8 display end");
        check("R8 count", a_total - base, 2);

        // R7: fixed address on character RAM
        one_cmd(8'h49);
        sess_open(); sess_byte(8'h85); sess_byte(8'h11); sess_byte(8'h22); sess_byte(8'h33); sess_close();
        compare_log("R7 fixed");

        // R8: out-of-range blocks, valid address recovers
        one_cmd(8'h41);
        sess_open(); sess_byte(8'h8A); sess_byte(8'h55); sess_close();
        compare_log("R8 blocked");
        sess_open(); sess_byte(8'h86); sess_byte(8'h66); sess_byte(8'h67); sess_close();
        compare_log("R8 recovered");

        // R9: user font rows, row 7 dropped, code fixed
        one_cmd(8'h42);
        sess_open(); sess_byte(8'h83); sess_byte(8'h1F); sess_byte(8'hB5);
        sess_byte(8'hE3); sess_byte(8'h4A); sess_close();
        compare_log("R9 rows");
        check("R9 count", a_total - base, 3);
        sess_open(); sess_byte(8'h93); sess_byte(8'h00); sess_close();
        compare_log("R9 code range");

        // R10: LED latch, command and data in one window
        sess_open(); sess_byte(8'h43); sess_byte(8'hA5); sess_close();
        check("R10 led", led, 4'h5); check_ctrl("R10");

        // R4: status layout
        one_cmd(8'hED); check_ctrl("R4");
        one_cmd(8'hD6); check_ctrl("R4");

        // R5: panel setup change blanks, repeat leaves status
        one_cmd(8'hCF);
        one_cmd(8'h05); check_ctrl("R5 change");
        check("R5 blank", {lcd, scan_en}, 3'b000);
        one_cmd(8'hCF);
        one_cmd(8'h05); check_ctrl("R5 same");
        check("R5 kept", {lcd, scan_en}, 3'b111);

        // R3: strobe drop in a data byte
        one_cmd(8'h40);
        sess_open(); sess_byte(8'h84); sess_byte(8'h5A); send_bits(8'hFF, 5); sess_close();
        compare_log("R3 data drop");
        // R3: strobe drop in a command byte
        sess_open(); send_bits(8'hC0, 6); sess_close();
        check_ctrl("R3 cmd drop");
        sess_open(); sess_byte(8'h88); sess_byte(8'h33); sess_close();
        compare_log("R3 reframe");

        // R11: key read, then one extra byte
        key = 32'h815A00FF;
        key_read("R11 key", 5);
        for (int n = 0; n < 3; n++) begin
            key = $urandom;
            key_read("R11 random key", 4);
        end

        // R12: strobe drop mid read releases the line
        key = 32'h00000000;
        sess_open(); sess_byte(8'h44); recv_bits(v, 3);
        check("R12 driving", pull, 1'b1);
        dat = 1'b1; stb = 1'b0; m_rd = 1'b0;
        wait_clks(6);
        check("R12 released", pull, 1'b0);
        wait_clks(2 * HALF);

        // R6 R7 R8 R9 R10: seeded random sessions
        for (int it = 0; it < 40; it++) begin
            logic [7:0] c;
            int nb;
            c = 8'h40 | {4'b0, 1'($urandom % 2), 3'($urandom % 4)};
            if (it % 9 == 8) c = 8'h45 + 8'($urandom % 3); // illegal modes 101..111
            one_cmd(c);
            nb = 1 + $urandom % 5;
            sess_open();
            sess_byte(8'h80 | 8'($urandom % 28));
            for (int j = 0; j < nb; j++) sess_byte(8'($urandom));
            sess_close();
            compare_log("R6 R7 R8 R9 random");
            if (it % 5 == 0) begin
                one_cmd(8'hC0 | 8'($urandom % 64));
                check_ctrl("R4 random");
            end
        end
        check_ctrl("R10 final");

        done = 1;
        summary();
        $finish;
    end

endmodule